// File: doc/BRIEF.md
# Operand Cache Array Access Port

This block lets software load and store the tag and data arrays of a direct-mapped operand cache. The cache holds 512 lines of 32 bytes, 16 KB in all. One 32-bit access address carries a region select bit, and that bit steers the access to the tag array or to the data array. A tag word packs a physical tag with a dirty flag and a valid flag.

Software can overwrite a tag. If the line it displaces is both valid and dirty, the block first sends that line to memory as an eight-beat burst, and only then stores the new tag. A separate control-register write can invalidate the whole cache. When it does, an internal sweep clears the valid and dirty flags of every line, one line per clock. While a burst or a sweep is in progress the access port reports busy, and the master holds its request until busy drops.

Top module: `ocache_array_port`

## Requirements
- R1: After reset every line is invalid, clean and has a zero tag, so a tag read returns 0. After reset `acc_busy`, `acc_rvalid` and `wb_valid` are low.
- R2: An access is accepted in a cycle where `acc_valid` is high and `acc_busy` is low. Address bit 24 set selects the data array and bit 24 clear selects the tag array. For tag accesses the line index is address bits [13:5]. For data accesses the word index is address bits [13:2].
- R3: An accepted tag read raises `acc_rvalid` for one cycle, on the clock after acceptance. `acc_rdata` then holds the line's tag word: tag in bits [28:10], dirty flag in bit 1, valid flag in bit 0, and zeros in every other bit.
- R4: A tag write with address bit 3 clear stores the written value ANDed with 0x1FFFFC03.
- R5: A tag write with address bit 3 set changes no tag, flag or data and starts no burst.
- R6: Before a bit-3-clear tag write overwrites a line that is both valid and dirty, the block sends that line as 8 beats. The burst address is bits [28:10] of the old tag joined to access address bits [9:5], with bits [4:0] zero. Beat k carries word k of the line. `wb_last` marks beat 7.
- R7: A beat moves on a clock where `wb_valid` and `wb_ready` are both high. While a beat is stalled, its address, data and last flag hold steady. `acc_busy` stays high for the whole burst. The new tag is stored on the clock that accepts the last beat, and busy is low on the next cycle.
- R8: A data write replaces the addressed 32-bit word, and a later data read returns it one cycle after acceptance with `acc_rvalid`.
- R9: A control write with bit 3 set, made while idle, clears the valid and dirty flags of all 512 lines and keeps the tags and data. `acc_busy` is high in that cycle and for the 512 cycles that follow. A control write with bit 3 clear has no effect.
- R10: A tag write over a line that is not both valid and dirty stores at once, starts no burst and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address (array select, index, mode) |
| acc_wdata | input | 32 | Store data |
| acc_busy | output | 1 | Access not accepted this cycle |
| acc_rvalid | output | 1 | Load result valid |
| acc_rdata | output | 32 | Load result |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control value; bit 3 requests full invalidate |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Write-back beat accepted |
| wb_addr | output | 32 | Write-back burst start address |
| wb_data | output | 32 | Write-back beat data |
| wb_last | output | 1 | Final beat of the burst |

## Verification
The assertions assume the master holds its request until `acc_busy` is low. They also assume control writes arrive only while the block is idle. The stimulus keeps to this by driving every access and control write on a falling edge, and only after it has seen busy low. The burst responder drops and raises `wb_ready` at random, so stalls happen both mid-burst and on the last beat. Random traffic is confined to sixteen lines whose data words are written first. Because those lines are so few, dirty lines are often overwritten, and every beat of every burst carries known data.

// File: rtl/ocache_pkg.sv
package ocache_pkg;
  localparam int TAG_HI = 28;
  localparam int TAG_LO = 10;
  localparam int TAG_W  = TAG_HI - TAG_LO + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FLUSH, ST_WALK} ctl_state_t;

  // Software-visible form of a tag entry.
  function automatic logic [31:0] tag_word(input logic [TAG_W-1:0] t,
                                           input logic d, input logic v);
    tag_word = {3'b000, t, 8'h00, d, v};
  endfunction

  // Memory address of a displaced line: old tag joined with low index bits.
  function automatic logic [31:0] flush_addr(input logic [TAG_W-1:0] t,
                                             input logic [4:0] low_idx);
    flush_addr = {3'b000, t, low_idx, 5'b00000};
  endfunction
endpackage

// File: rtl/ocache_tag_store.sv
module ocache_tag_store
  import ocache_pkg::*;
#(
  parameter int LINES = 512,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic             wr_valid,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  assign rd_tag   = tag_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
      dirty_q[clr_idx] <= 1'b0;
    end else if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // R9: the swept line ends up invalid and clean
  assert_clear_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (!valid_q[$past(clr_idx)] && !dirty_q[$past(clr_idx)]));
endmodule

// File: rtl/ocache_data_store.sv
module ocache_data_store #(
  parameter int WORDS  = 4096,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [WORDS];

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // R8: a stored word is present on the next cycle
  assert_word_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/ocache_ctrl.sv
module ocache_ctrl
  import ocache_pkg::*;
#(
  parameter int LINES     = 512,
  parameter int WPL       = 8,
  parameter int SEL_BIT   = 24,
  parameter int ASSOC_BIT = 3,
  parameter int INV_BIT   = 3,
  localparam int IDX_W    = $clog2(LINES),
  localparam int OFF_W    = $clog2(WPL),
  localparam int WAW      = IDX_W + OFF_W,
  localparam int LINE_SH  = OFF_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_addr,
  input  logic [31:0]      acc_wdata,
  output logic             busy,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  output logic             wb_valid,
  output logic [31:0]      wb_addr,
  output logic             wb_last,
  input  logic             wb_ready,
  input  logic [31:0]      beat_data,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             line_dirty,
  input  logic             line_valid,
  input  logic [31:0]      word_data,
  output logic [IDX_W-1:0] line_idx,
  output logic             tag_wr_en,
  output logic [TAG_W-1:0] tag_wr_tag,
  output logic             tag_wr_dirty,
  output logic             tag_wr_valid,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             data_wr_en,
  output logic [WAW-1:0]   word_addr,
  output logic [WAW-1:0]   beat_addr
);
  ctl_state_t       state;
  logic [IDX_W-1:0] fl_idx, walk_idx, acc_idx;
  logic [TAG_W-1:0] fl_tag;
  logic             fl_d, fl_v;
  logic [31:0]      fl_addr;
  logic [OFF_W-1:0] beat;
  logic             rd_valid_q;
  logic [31:0]      rd_data_q;

  // Named internal events
  logic inv_go, acc_fire, sel_data, assoc, tag_wr_req, flush_start, flush_done;

  assign inv_go      = ctl_wr && ctl_wdata[INV_BIT] && (state == ST_IDLE);
  assign busy        = (state != ST_IDLE) || inv_go;
  assign acc_fire    = acc_valid && !busy;
  assign sel_data    = acc_addr[SEL_BIT];
  assign assoc       = acc_addr[ASSOC_BIT];
  assign acc_idx     = acc_addr[LINE_SH +: IDX_W];
  assign tag_wr_req  = acc_fire && acc_write && !sel_data && !assoc;
  assign flush_start = tag_wr_req && line_valid && line_dirty;
  assign wb_valid    = (state == ST_FLUSH);
  assign wb_last     = (beat == OFF_W'(WPL - 1));
  assign flush_done  = wb_valid && wb_ready && wb_last;
  assign wb_addr     = fl_addr;

  assign line_idx     = (state == ST_FLUSH) ? fl_idx : acc_idx;
  assign tag_wr_en    = (tag_wr_req && !flush_start) || flush_done;
  assign tag_wr_tag   = (state == ST_FLUSH) ? fl_tag : acc_wdata[TAG_HI:TAG_LO];
  assign tag_wr_dirty = (state == ST_FLUSH) ? fl_d : acc_wdata[1];
  assign tag_wr_valid = (state == ST_FLUSH) ? fl_v : acc_wdata[0];

  assign data_wr_en = acc_fire && acc_write && sel_data;
  assign word_addr  = acc_addr[2 +: WAW];
  assign beat_addr  = {fl_idx, beat};
  assign clr_en     = (state == ST_WALK);
  assign clr_idx    = walk_idx;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fl_idx     <= '0;
      fl_tag     <= '0;
      fl_d       <= 1'b0;
      fl_v       <= 1'b0;
      fl_addr    <= '0;
      beat       <= '0;
      walk_idx   <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc_fire && !acc_write;
      if (acc_fire && !acc_write)
        rd_data_q <= sel_data ? word_data : tag_word(line_tag, line_dirty, line_valid);
      unique case (state)
        ST_IDLE: begin
          if (inv_go) begin
            state    <= ST_WALK;
            walk_idx <= '0;
          end else if (flush_start) begin
            state   <= ST_FLUSH;
            fl_idx  <= acc_idx;
            fl_tag  <= acc_wdata[TAG_HI:TAG_LO];
            fl_d    <= acc_wdata[1];
            fl_v    <= acc_wdata[0];
            fl_addr <= flush_addr(line_tag, acc_addr[9:5]);
            beat    <= '0;
          end
        end
        ST_FLUSH: begin
          if (wb_ready) begin
            beat <= beat + 1'b1;
            if (wb_last) state <= ST_IDLE;
          end
        end
        ST_WALK: begin
          walk_idx <= walk_idx + 1'b1;
          if (walk_idx == IDX_W'(LINES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a load gets its result one clock later
  assert_read_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_write) |=> rd_valid);
  // R5: associative-mode tag stores touch nothing
  assert_assoc_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_write && !sel_data && assoc) |-> (!tag_wr_en && !flush_start));
  // R6: a valid dirty line is only overwritten at the end of its burst
  assert_flush_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_wr_en && line_valid && line_dirty) |-> (state == ST_FLUSH));
  // R7: a stalled beat keeps its payload
  assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_last)
                                 && $stable(beat_data)));
  // R9: the sweep runs only while the port is busy
  assert_walk_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> busy);
endmodule

// File: rtl/ocache_array_port.sv
module ocache_array_port
  import ocache_pkg::*;
#(
  parameter int LINES     = 512,
  parameter int WPL       = 8,
  parameter int SEL_BIT   = 24,
  parameter int ASSOC_BIT = 3,
  parameter int INV_BIT   = 3,
  localparam int IDX_W    = $clog2(LINES),
  localparam int OFF_W    = $clog2(WPL),
  localparam int WAW      = IDX_W + OFF_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        acc_busy,
  output logic        acc_rvalid,
  output logic [31:0] acc_rdata,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  output logic        wb_valid,
  input  logic        wb_ready,
  output logic [31:0] wb_addr,
  output logic [31:0] wb_data,
  output logic        wb_last
);
  logic [TAG_W-1:0] line_tag, tag_wr_tag;
  logic             line_dirty, line_valid;
  logic [IDX_W-1:0] line_idx, clr_idx;
  logic             tag_wr_en, tag_wr_dirty, tag_wr_valid, clr_en, data_wr_en;
  logic [WAW-1:0]   word_addr, beat_addr;
  logic [31:0]      word_data;

  ocache_ctrl #(.LINES(LINES), .WPL(WPL), .SEL_BIT(SEL_BIT),
                .ASSOC_BIT(ASSOC_BIT), .INV_BIT(INV_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .busy(acc_busy), .rd_valid(acc_rvalid),
    .rd_data(acc_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_last(wb_last),
    .wb_ready(wb_ready), .beat_data(wb_data),
    .line_tag(line_tag), .line_dirty(line_dirty), .line_valid(line_valid),
    .word_data(word_data), .line_idx(line_idx),
    .tag_wr_en(tag_wr_en), .tag_wr_tag(tag_wr_tag),
    .tag_wr_dirty(tag_wr_dirty), .tag_wr_valid(tag_wr_valid),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .data_wr_en(data_wr_en), .word_addr(word_addr), .beat_addr(beat_addr)
  );

  ocache_tag_store #(.LINES(LINES)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(line_idx), .rd_tag(line_tag), .rd_dirty(line_dirty),
    .rd_valid(line_valid),
    .wr_en(tag_wr_en), .wr_idx(line_idx), .wr_tag(tag_wr_tag),
    .wr_dirty(tag_wr_dirty), .wr_valid(tag_wr_valid),
    .clr_en(clr_en), .clr_idx(clr_idx)
  );

  ocache_data_store #(.WORDS(LINES * WPL), .DATA_W(32)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_wr_en), .wr_addr(word_addr), .wr_data(acc_wdata),
    .ra_addr(word_addr), .ra_data(word_data),
    .rb_addr(beat_addr), .rb_data(wb_data)
  );
endmodule

// File: tb/ocache_array_port_bench.sv
module ocache_array_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_busy, acc_rvalid;
  logic [31:0] acc_rdata;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        wb_valid, wb_last;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_addr, wb_data;

  int n_checks = 0, n_fail = 0;
  logic [31:0] m_tag [512];
  logic [31:0] m_data [4096];
  int work_set [16];

  always #10 clk = ~clk;

  ocache_array_port u_ocache_array_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_busy(acc_busy),
    .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_last(wb_last));

  function automatic logic [31:0] tag_addr(int idx, bit assoc_mode);
    return (32'(idx) << 5) | (assoc_mode ? 32'h8 : 32'h0);
  endfunction
  function automatic logic [31:0] data_addr(int widx);
    return 32'h0100_0000 | (32'(widx) << 2);
  endfunction
  function automatic logic [31:0] exp_wb_addr(int idx);
    return (m_tag[idx] & 32'h1FFF_FC00) | (32'(idx & 31) << 5);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (acc_busy) @(negedge clk);
  endtask

  task automatic do_read(logic [31:0] addr, output logic [31:0] val);
    wait_idle();
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    check(acc_rvalid == 1'b1, "R3 rvalid", 32'(acc_rvalid), 32'h1);
    val = acc_rdata;
  endtask

  task automatic data_write(int widx, logic [31:0] v);
    wait_idle();
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = data_addr(widx); acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0;
    m_data[widx] = v;
  endtask

  task automatic check_data(int widx);
    logic [31:0] v;
    do_read(data_addr(widx), v);
    check(v == m_data[widx], "R8 data readback", v, m_data[widx]);
  endtask

  task automatic check_tag(int idx, string req);
    logic [31:0] v;
    do_read(tag_addr(idx, 1'b0), v);
    check(v == m_tag[idx], req, v, m_tag[idx]);
  endtask

  task automatic tag_write(int idx, logic [31:0] v, bit assoc_mode);
    bit expect_flush;
    int beats, guard;
    logic [31:0] ea;
    expect_flush = !assoc_mode && (m_tag[idx][1:0] == 2'b11);
    ea = exp_wb_addr(idx);
    wait_idle();
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = tag_addr(idx, assoc_mode); acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0;
    if (!expect_flush) begin
      check(!acc_busy && !wb_valid, assoc_mode ? "R5 no burst" : "R10 no burst",
            {30'b0, acc_busy, wb_valid}, 32'h0);
    end else begin
      check(acc_busy, "R7 busy in burst", 32'(acc_busy), 32'h1);
      beats = 0; guard = 0;
      while (beats < 8 && guard < 400) begin
        bit r;
        r = ($urandom % 3) != 0;
        wb_ready = r;
        if (r && wb_valid) begin
          check(wb_addr == ea, "R6 burst address", wb_addr, ea);
          check(wb_data == m_data[idx*8 + beats], "R6 beat data", wb_data, m_data[idx*8 + beats]);
          check(wb_last == (beats == 7), "R6 last flag", 32'(wb_last), 32'(beats == 7));
          beats++;
        end
        @(negedge clk);
        guard++;
      end
      wb_ready = 1'b0;
      check(beats == 8, "R6 beat count", 32'(beats), 32'd8);
      check(!acc_busy && !wb_valid, "R7 busy drops after last beat",
            {30'b0, acc_busy, wb_valid}, 32'h0);
    end
    if (!assoc_mode) m_tag[idx] = v & 32'h1FFF_FC03;
  endtask

  task automatic ctl_write(logic [31:0] v, output int busy_cycles);
    wait_idle();
    ctl_wr = 1'b1; ctl_wdata = v;
    #1;
    if (v[3]) check(acc_busy, "R9 busy on invalidate", 32'(acc_busy), 32'h1);
    @(negedge clk);
    ctl_wr = 1'b0;
    busy_cycles = 0;
    while (acc_busy && busy_cycles < 2000) begin
      busy_cycles++;
      @(negedge clk);
    end
    if (v[3]) for (int i = 0; i < 512; i++) m_tag[i] &= ~32'h3;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int bc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) m_tag[i] = '0;
    for (int i = 0; i < 4096; i++) m_data[i] = '0;
    for (int k = 0; k < 16; k++) work_set[k] = (k * 31 + 5) % 512;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!acc_busy && !acc_rvalid && !wb_valid, "R1 idle outputs",
          {29'b0, acc_busy, acc_rvalid, wb_valid}, 32'h0);
    check_tag(0, "R1 tag zero");
    check_tag(511, "R1 tag zero");
    check_tag(work_set[3], "R1 tag zero");

    // Fill data of the working set (R8, R2 word index)
    for (int k = 0; k < 16; k++)
      for (int w = 0; w < 8; w++) data_write(work_set[k]*8 + w, $urandom);
    check_data(work_set[0]*8);
    check_data(work_set[15]*8 + 7);

    // R2 word index boundary: top and bottom words
    data_write(4095, 32'hCAFE_F00D);
    data_write(0, 32'h1234_5678);
    check_data(4095);
    check_data(0);

    // R4 mask, R10 no flush on clean line
    tag_write(5, 32'hFFFF_FFFF, 1'b0);
    check_tag(5, "R4 masked tag");
    // R5 associative write ignored
    tag_write(5, 32'h0000_0000, 1'b1);
    check_tag(5, "R5 assoc ignored");
    // R6/R7 dirty overwrite
    for (int w = 0; w < 8; w++) data_write(5*8 + w, 32'hA000_0000 + 32'(w));
    tag_write(5, 32'h0000_0401, 1'b0);
    check_tag(5, "R7 tag after burst");
    check_data(5*8 + 3);
    // valid but clean: no burst (R10)
    tag_write(5, 32'h1234_5402, 1'b0);
    check_tag(5, "R10 dirty-only stored");
    tag_write(5, 32'h0000_0C01, 1'b0);
    check_tag(5, "R10 clean overwrite");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      idx = work_set[$urandom % 16];
      op = $urandom % 4;
      case (op)
        0: data_write(idx*8 + int'($urandom % 8), $urandom);
        1: check_data(idx*8 + int'($urandom % 8));
        2: tag_write(idx, $urandom | (($urandom % 2) ? 32'h3 : 32'h0), ($urandom % 8) == 0);
        default: check_tag(idx, "R3 tag word");
      endcase
    end

    // R9 control write without bit 3 does nothing
    for (int k = 0; k < 16; k++) tag_write(work_set[k], 32'h0ABC_D403 + 32'(k << 10), 1'b0);
    ctl_write(32'hFFFF_FFF7, bc);
    check(bc == 0, "R9 no sweep without bit 3", 32'(bc), 32'h0);
    check_tag(work_set[2], "R9 no effect");
    // R9 full invalidate
    ctl_write(32'h0000_0008, bc);
    check(bc == 512, "R9 sweep length", 32'(bc), 32'd512);
    for (int k = 0; k < 16; k++) check_tag(work_set[k], "R9 flags cleared");
    check_tag(511, "R9 flags cleared");
    check_data(work_set[4]*8 + 2);
    // former dirty line now clean: no burst
    tag_write(work_set[7], 32'h0000_0403, 1'b0);
    check_tag(work_set[7], "R10 after sweep");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule